// File: doc/BRIEF.md
# Bus Latch with Preset and Clear

This block is a parameterised bank of transparent storage bits placed between a data source and a shared bus. While the latch enable is high, each output bit follows its data input. When the enable falls, the value on the data inputs is kept. An active-low preset loads all ones. An active-low clear loads all zeros. Both act at once, without a clock, and preset wins when both are low.

A group of active-low output enables gates the tri-state output bus. The bus is driven only when every enable is low, so several masters (a chip select, a DMA grant, a read strobe) can each hold the bus off independently. A power-on reset input models start-up: it empties the storage and floats the bus until it is released. The design has no clock. Every path is level-sensitive.

Top module: `bus_latch_top`

## Requirements
- R1: While `porN` is 0, the stored value is 0 and every bit of `qBus` is high impedance, whatever the other inputs are.
- R2: With `porN` at 1, `qBus` is driven only when every bit of `oeN` is 0. If any single bit of `oeN` is 1, every bit of `qBus` is high impedance.
- R3: Changing `oeN` never alters the stored value. After the bus is enabled again, it shows the value held before it was floated.
- R4: While `presetN` is 0, every stored bit is 1, regardless of `latchEn`, `dIn` and `clearN`.
- R5: While `clearN` is 0 and `presetN` is 1, every stored bit is 0, regardless of `latchEn` and `dIn`.
- R6: With `presetN` and `clearN` both at 1 and `latchEn` at 1, the stored value (and the driven `qBus`) equals `dIn`.
- R7: On the 1-to-0 transition of `latchEn`, the value on `dIn` is kept as the stored value.
- R8: While `latchEn` is 0 and `presetN` and `clearN` are both 1, the stored value does not change when `dIn` changes.
- R9: When preset or clear is released while `latchEn` is 0, the forced value (all ones or all zeros) remains stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| porN | input | 1 | Power-on reset, active low |
| latchEn | input | 1 | Latch enable, transparent when high |
| presetN | input | 1 | Asynchronous set to all ones, active low, highest priority after power-on reset |
| clearN | input | 1 | Asynchronous clear to all zeros, active low |
| oeN | input | NUM_OE (3) | Output enables, active low, all must be low to drive |
| dIn | input | WIDTH (8) | Data inputs |
| qBus | output | WIDTH (8) | Tri-state data outputs |

## Verification
Preset and clear can be asserted at the same moment. The bench asserts both with the latch transparent and data that has mixed bit values. The driven bus must then read all ones. The bench then releases preset first, with the enable held low, and expects the clear to bring the bus to zero. It also releases the two controls in both orders and checks which forced value stays stored. The output gating is exercised while the bus is forced, so that a wrong priority shows up when the bus is driven again, not only in an internal state.

// File: rtl/bus_latch_pkg.sv
package bus_latch_pkg;
  typedef struct packed {
    logic forceOne;
    logic forceZero;
    logic loadEn;
    logic driveEn;
  } latchStrobes_t;
endpackage

// File: rtl/bus_latch_ctrl.sv
module bus_latch_ctrl
  import bus_latch_pkg::*;
#(
  parameter int NUM_OE = 3
) (
  input  logic              porN,
  input  logic              latchEn,
  input  logic              presetN,
  input  logic              clearN,
  input  logic [NUM_OE-1:0] oeN,
  output latchStrobes_t     strobes
);
  logic allEnabled;

  always_comb begin
    allEnabled = 1'b1;
    for (int i = 0; i < NUM_OE; i++) begin
      if (oeN[i]) allEnabled = 1'b0;
    end
  end

  always_comb begin
    strobes.forceOne  = porN & ~presetN;
    strobes.forceZero = ~porN | ~clearN;
    strobes.loadEn    = latchEn;
    strobes.driveEn   = porN & allEnabled;
  end

  // p_por_floats_r1: power-on reset never lets the bus be driven
  always_comb begin
    if (!porN) p_por_floats_r1: assert (!strobes.driveEn);
  end
endmodule

// File: rtl/bus_latch_store.sv
module bus_latch_store
  import bus_latch_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  latchStrobes_t    strobes,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] heldBits,
  output logic [WIDTH-1:0] qBus
);
  always_latch begin
    if (strobes.forceOne)       heldBits = '1;
    else if (strobes.forceZero) heldBits = '0;
    else if (strobes.loadEn)    heldBits = dIn;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_drive
    assign qBus[b] = strobes.driveEn ? heldBits[b] : 1'bz;
  end

  always_comb begin
    if (strobes.forceOne) p_preset_ones_r4: assert (heldBits == '1);
  end

  always_comb begin
    if (strobes.forceZero && !strobes.forceOne)
      p_clear_zeros_r5: assert (heldBits == '0);
  end

  always_comb begin
    if (strobes.loadEn && !strobes.forceOne && !strobes.forceZero)
      p_transparent_r6: assert (heldBits == dIn);
  end
endmodule

// File: rtl/bus_latch_top.sv
module bus_latch_top
  import bus_latch_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int NUM_OE = 3
) (
  input  logic              porN,
  input  logic              latchEn,
  input  logic              presetN,
  input  logic              clearN,
  input  logic [NUM_OE-1:0] oeN,
  input  logic [WIDTH-1:0]  dIn,
  output logic [WIDTH-1:0]  qBus
);
  localparam logic [WIDTH-1:0] ALL_Z = {WIDTH{1'bz}};

  latchStrobes_t    strobes;
  logic [WIDTH-1:0] heldBits;

  bus_latch_ctrl #(.NUM_OE(NUM_OE)) i_ctrl (
    .porN    (porN),
    .latchEn (latchEn),
    .presetN (presetN),
    .clearN  (clearN),
    .oeN     (oeN),
    .strobes (strobes)
  );

  bus_latch_store #(.WIDTH(WIDTH)) i_store (
    .strobes  (strobes),
    .dIn      (dIn),
    .heldBits (heldBits),
    .qBus     (qBus)
  );

  // p_any_oe_floats_r2: a single raised enable floats the whole bus
  always_comb begin
    if (porN && (|oeN)) p_any_oe_floats_r2: assert (qBus === ALL_Z);
  end

  always_comb begin
    if (!porN) p_por_bus_z_r1: assert (qBus === ALL_Z);
  end

  always_comb begin
    if (porN && oeN == '0) p_bus_shows_store_r2: assert (qBus === heldBits);
  end
endmodule

// File: tb/test_bus_latch_top.sv
module test_bus_latch_top;
  localparam int WIDTH  = 8;
  localparam int NUM_OE = 3;
  localparam logic [WIDTH-1:0] ALL_Z = {WIDTH{1'bz}};

  logic              clk = 1'b0;
  logic              porN, latchEn, presetN, clearN;
  logic [NUM_OE-1:0] oeN;
  logic [WIDTH-1:0]  dIn;
  logic [WIDTH-1:0]  qBus;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_latch_top #(.WIDTH(WIDTH), .NUM_OE(NUM_OE)) i_bus_latch_top (
    .porN(porN), .latchEn(latchEn), .presetN(presetN), .clearN(clearN),
    .oeN(oeN), .dIn(dIn), .qBus(qBus)
  );

  task automatic expectBus(input logic [WIDTH-1:0] exp, input string req);
    @(negedge clk);
    checks++;
    if (qBus !== exp) begin
      failures++;
      $display("FAIL %s: qBus=%b expected=%b", req, qBus, exp);
    end
  endtask

  task automatic drive(input logic le, input logic pre, input logic clr,
                       input logic [NUM_OE-1:0] oe, input logic [WIDTH-1:0] d);
    @(posedge clk);
    latchEn = le; presetN = pre; clearN = clr; oeN = oe; dIn = d;
  endtask

  task automatic testPowerOn;
    @(posedge clk);
    porN = 1'b0; latchEn = 1'b1; presetN = 1'b1; clearN = 1'b1; oeN = '0; dIn = 8'hA5;
    expectBus(ALL_Z, "R1 bus floats in power-on reset");
    drive(1'b0, 1'b1, 1'b1, '0, 8'h3C);
    @(posedge clk) porN = 1'b1;
    expectBus(8'h00, "R1 storage cleared by power-on reset");
  endtask

  task automatic testTransparent;
    drive(1'b1, 1'b1, 1'b1, '0, 8'h5A);
    expectBus(8'h5A, "R6 transparent 5A");
    drive(1'b1, 1'b1, 1'b1, '0, 8'hC3);
    expectBus(8'hC3, "R6 transparent C3");
  endtask

  task automatic testCaptureHold;
    drive(1'b1, 1'b1, 1'b1, '0, 8'h96);
    drive(1'b0, 1'b1, 1'b1, '0, 8'h96);
    expectBus(8'h96, "R7 capture on enable fall");
    drive(1'b0, 1'b1, 1'b1, '0, 8'h0F);
    expectBus(8'h96, "R8 hold against data 0F");
    drive(1'b0, 1'b1, 1'b1, '0, 8'hFF);
    expectBus(8'h96, "R8 hold against data FF");
  endtask

  task automatic testEnables;
    for (int i = 0; i < NUM_OE; i++) begin
      drive(1'b0, 1'b1, 1'b1, NUM_OE'(1 << i), 8'h11);
      expectBus(ALL_Z, $sformatf("R2 enable bit %0d floats bus", i));
    end
    drive(1'b0, 1'b1, 1'b1, '1, 8'h22);
    expectBus(ALL_Z, "R2 all enables high float bus");
    drive(1'b0, 1'b1, 1'b1, '0, 8'h33);
    expectBus(8'h96, "R3 stored value kept across disable");
  endtask

  task automatic testPresetClear;
    drive(1'b1, 1'b0, 1'b1, '0, 8'h24);
    expectBus(8'hFF, "R4 preset over transparent data");
    drive(1'b1, 1'b0, 1'b0, '0, 8'h5A);
    expectBus(8'hFF, "R4 preset wins over clear");
    drive(1'b0, 1'b1, 1'b0, '0, 8'h5A);
    expectBus(8'h00, "R5 clear after preset release");
    drive(1'b1, 1'b1, 1'b0, '0, 8'hE7);
    expectBus(8'h00, "R5 clear over transparent data");
    drive(1'b0, 1'b1, 1'b1, '0, 8'hE7);
    expectBus(8'h00, "R9 zero stays after clear release");
    drive(1'b0, 1'b0, 1'b1, '1, 8'h18);
    drive(1'b0, 1'b1, 1'b1, '0, 8'h18);
    expectBus(8'hFF, "R9 ones stay after preset release while floated");
  endtask

  initial begin
    porN = 1'b0; latchEn = 1'b0; presetN = 1'b1; clearN = 1'b1; oeN = '1; dIn = '0;
    repeat (2) @(posedge clk);
    testPowerOn();
    testTransparent();
    testCaptureHold();
    testEnables();
    testPresetClear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule